// File: doc/BRIEF.md
# Cycle-Steal Four-Channel DMA Engine

This engine moves data between addresses in a 20-bit byte space. It does this by borrowing a bus that it shares with a processor. Each channel holds three pointers:

- a preset source pointer,
- a preset destination pointer,
- a forward pointer that does the advancing.

Each channel also holds a 16-bit down-counter, the reload value for that counter, and a control register. Every accepted request, from a hardware line or from a software trigger, causes exactly one stolen transfer of a byte or a 16-bit word. The engine raises a bus request and waits for the grant. It then reads the unit into an internal buffer, writes it out, and drops the request again.

Software programs a channel through a register write port. The selectors are 0 for the source pointer, 1 for the destination pointer, 2 for the counter reload value and 3 for control. The control fields are:

- bit 0: enable,
- bit 1: word width,
- bit 2: repeat mode,
- bit 3: source advances,
- bit 4: destination advances.

The counter ends a run when it underflows. At that moment the channel pulses its interrupt line. In single mode it also clears its own enable. In repeat mode it reloads the counter and keeps running.

The bus sequencer has four states. IDLE (bus released) moves to CLAIM when any enabled channel has a latched request. CLAIM (bus request raised) moves to READ once the grant is seen. READ (one read cycle, data buffered) always moves to WRITE. WRITE (one write cycle) always returns to IDLE, which releases the bus.

Top module: `steal_dma`

## Requirements
- R1: When several enabled channels have requests latched, the lowest-numbered channel is served first. The other channels are then served in rising index order.
- R2: Each serviced request reads one unit at the channel's read address and writes it to the channel's write address. A word transfer carries all 16 bits. A byte transfer writes the low 8 bits, with the upper 8 bits of write data driven to zero; `mem_wide` shows the width.
- R3: The advancing address steps by 1 after a byte transfer and by 2 after a word transfer. It wraps within 20 bits. A non-advancing address stays at its preset value.
- R4: Exactly one of source or destination advances, or neither does. A control write that sets both advance bits (bits 3 and 4) is stored with both cleared, so both addresses stay fixed.
- R5: With reload value N, the counter underflows on transfer N+1 of a run. Each underflow raises the channel's `irq` bit.
- R6: In single mode (control bit 2 = 0) the channel disables itself at underflow. Later requests move no data until software enables it again.
- R7: In repeat mode (bit 2 = 1) the counter reloads at each underflow, transfers continue, and `irq` fires once every N+1 transfers.
- R8: Every `irq` pulse lasts exactly one clock cycle, and reset leaves all `irq` bits low.
- R9: A request that arrives while its channel is disabled is dropped, not latched. Clearing the enable bit also discards a latched request.
- R10: On the first transfer after enable goes from 0 to 1, the forward pointer loads from the advancing preset and the counter loads from the reload value. Re-enabling therefore restarts from the presets.
- R11: A transfer holds `bus_req` from CLAIM through WRITE. It moves no data before the grant, performs one read cycle and then one write cycle, and releases the bus afterwards. This is 3 cycles when the grant is immediate, and the bus is idle after reset.
- R12: A request is latched while its channel waits for the bus. A second request before service does not queue, so only one transfer follows.
- R13: A software trigger pulse on a channel acts exactly like a hardware request on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_chan | input | 2 | Channel addressed by the write |
| cfg_sel | input | 2 | Register selector: 0 source, 1 destination, 2 reload, 3 control |
| cfg_data | input | 20 | Write data; reload uses bits 15:0, control uses bits 4:0 |
| req_in | input | 4 | Per-channel hardware request pulses |
| sw_trig | input | 4 | Per-channel software trigger pulses |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_addr | output | 20 | Memory byte address |
| mem_re | output | 1 | Read cycle strobe |
| mem_we | output | 1 | Write cycle strobe |
| mem_wide | output | 1 | 1 = 16-bit unit, 0 = byte |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid during the read cycle |
| irq | output | 4 | Per-channel underflow pulses |

## Verification
The assertions assume three things about the inputs:

- The grant stays high from the moment it is given until the bus is released.
- Requests are single-cycle pulses.
- Software does not rewrite a channel's control register while that channel has a transfer in flight.

The bench grants the bus combinationally from `bus_req`, with an enable it can hold off to model a busy bus. It spaces request pulses wider than one transfer. It reprograms a channel only after a settling gap, and it disables the channel first, so that every enable is a genuine 0-to-1 edge.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
    localparam int ADDR_W = 20;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 16;
    localparam int NUM_CH = 4;

    typedef enum logic [1:0] {
        SEL_SRC = 2'd0,
        SEL_DST = 2'd1,
        SEL_RLD = 2'd2,
        SEL_CTL = 2'd3
    } reg_sel_e;

    // Packed from MSB: bit4 dst_adv .. bit0 en
    typedef struct packed {
        logic dst_adv;
        logic src_adv;
        logic rpt;
        logic wide;
        logic en;
    } chan_ctl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLAIM = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } bus_state_e;
endpackage

// File: rtl/sdma_channel.sv
module sdma_channel
    import sdma_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          req_in,
    input  logic          start,
    input  logic          done,
    output logic          pending,
    output logic          wide,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] wr_addr,
    output logic          irq
);
    logic [AW-1:0] src_q, dst_q, fwd_q, step;
    logic [CW-1:0] rld_q, cnt_q;
    chan_ctl_t     ctl_q, ctl_new;
    logic          first_q, pend_q, irq_q, at_floor;

    always_comb begin
        ctl_new = chan_ctl_t'(wr_data[4:0]);
        if (ctl_new.src_adv && ctl_new.dst_adv) begin
            ctl_new.src_adv = 1'b0;
            ctl_new.dst_adv = 1'b0;
        end
    end

    assign step     = ctl_q.wide ? AW'(2) : AW'(1);
    assign at_floor = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= '0;
            dst_q   <= '0;
            fwd_q   <= '0;
            rld_q   <= '0;
            cnt_q   <= '0;
            ctl_q   <= '0;
            first_q <= 1'b0;
            pend_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= done && at_floor;
            if (start) begin
                pend_q <= 1'b0;
                if (first_q) begin
                    first_q <= 1'b0;
                    cnt_q   <= rld_q;
                    fwd_q   <= ctl_q.src_adv ? src_q : dst_q;
                end
            end
            if (req_in && ctl_q.en) begin
                pend_q <= 1'b1;
            end
            if (done) begin
                if (ctl_q.src_adv || ctl_q.dst_adv) begin
                    fwd_q <= fwd_q + step;
                end
                if (at_floor) begin
                    if (ctl_q.rpt) begin
                        cnt_q <= rld_q;
                    end else begin
                        ctl_q.en <= 1'b0;
                        pend_q   <= 1'b0;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            if (wr_en) begin
                unique case (reg_sel_e'(wr_sel))
                    SEL_SRC: src_q <= wr_data;
                    SEL_DST: dst_q <= wr_data;
                    SEL_RLD: rld_q <= wr_data[CW-1:0];
                    SEL_CTL: begin
                        ctl_q <= ctl_new;
                        if (ctl_new.en && !ctl_q.en) first_q <= 1'b1;
                        if (!ctl_new.en)             pend_q  <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign pending = pend_q && ctl_q.en;
    assign wide    = ctl_q.wide;
    assign rd_addr = ctl_q.src_adv ? fwd_q : src_q;
    assign wr_addr = ctl_q.dst_adv ? fwd_q : dst_q;
    assign irq     = irq_q;

    // R4
    dir_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_q.src_adv && ctl_q.dst_adv));
    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !at_floor) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R6
    single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && at_floor && !ctl_q.rpt && !wr_en) |=> !ctl_q.en);
endmodule

// File: rtl/sdma_arbiter.sv
module sdma_arbiter #(
    parameter int NCH = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] pend,
    output logic           valid,
    output logic [IW-1:0]  idx
);
    logic [NCH-1:0] lower_mask;

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    assign lower_mask = ({{(NCH-1){1'b0}}, 1'b1} << idx) - 1'b1;

    // R1
    always_comb begin
        if (valid) begin
            lowest_pick_chk: assert (pend[idx] && ((pend & lower_mask) == '0));
        end
    end
endmodule

// File: rtl/sdma_sequencer.sv
module sdma_sequencer
    import sdma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pick_valid,
    input  logic [IW-1:0]  pick_idx,
    input  logic           bus_gnt,
    input  logic [AW-1:0]  rd_addr,
    input  logic [AW-1:0]  wr_addr,
    input  logic           wide,
    input  logic [DW-1:0]  mem_rdata,
    output logic [IW-1:0]  cur_idx,
    output logic [NCH-1:0] start_vec,
    output logic [NCH-1:0] done_vec,
    output logic           bus_req,
    output logic           mem_re,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_wide,
    output logic [DW-1:0]  mem_wdata
);
    bus_state_e    state_q, state_d;
    logic [IW-1:0] cur_q;
    logic [DW-1:0] buf_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pick_valid) state_d = ST_CLAIM;
            ST_CLAIM: if (bus_gnt)    state_d = ST_READ;
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            buf_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && pick_valid) cur_q <= pick_idx;
            if (state_q == ST_READ)               buf_q <= mem_rdata;
        end
    end

    always_comb begin
        bus_req   = 1'b0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        start_vec = '0;
        done_vec  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_CLAIM: begin
                bus_req = 1'b1;
                if (bus_gnt) start_vec[cur_q] = 1'b1;
            end
            ST_READ: begin
                bus_req  = 1'b1;
                mem_re   = 1'b1;
                mem_addr = rd_addr;
            end
            ST_WRITE: begin
                bus_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = wr_addr;
                done_vec[cur_q] = 1'b1;
            end
        endcase
    end

    assign cur_idx   = cur_q;
    assign mem_wide  = wide;
    assign mem_wdata = wide ? buf_q : {{(DW-8){1'b0}}, buf_q[7:0]};

    // R11
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> mem_we);
    // R11
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !bus_req);
    // R11
    read_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (bus_req && bus_gnt));
    // R1
    one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_vec));
endmodule

// File: rtl/steal_dma.sv
module steal_dma
    import sdma_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int AW  = ADDR_W,
    parameter int CW  = CNT_W,
    parameter int DW  = DATA_W,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [IW-1:0]  cfg_chan,
    input  logic [1:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_data,
    input  logic [NCH-1:0] req_in,
    input  logic [NCH-1:0] sw_trig,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_re,
    output logic           mem_we,
    output logic           mem_wide,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic [NCH-1:0] irq
);
    logic [NCH-1:0] pend, start_vec, done_vec, ch_wide;
    logic [AW-1:0]  ch_rd [NCH];
    logic [AW-1:0]  ch_wr [NCH];
    logic           pick_valid;
    logic [IW-1:0]  pick_idx, cur_idx;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        sdma_channel #(.AW(AW), .CW(CW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && (cfg_chan == IW'(g))),
            .wr_sel  (cfg_sel),
            .wr_data (cfg_data),
            .req_in  (req_in[g] || sw_trig[g]),
            .start   (start_vec[g]),
            .done    (done_vec[g]),
            .pending (pend[g]),
            .wide    (ch_wide[g]),
            .rd_addr (ch_rd[g]),
            .wr_addr (ch_wr[g]),
            .irq     (irq[g])
        );
    end

    sdma_arbiter #(.NCH(NCH)) u_arb (
        .pend  (pend),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    sdma_sequencer #(.NCH(NCH), .AW(AW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx),
        .bus_gnt    (bus_gnt),
        .rd_addr    (ch_rd[cur_idx]),
        .wr_addr    (ch_wr[cur_idx]),
        .wide       (ch_wide[cur_idx]),
        .mem_rdata  (mem_rdata),
        .cur_idx    (cur_idx),
        .start_vec  (start_vec),
        .done_vec   (done_vec),
        .bus_req    (bus_req),
        .mem_re     (mem_re),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wide   (mem_wide),
        .mem_wdata  (mem_wdata)
    );
endmodule

// File: tb/steal_dma_bench.sv
module steal_dma_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_chan = '0;
    logic [1:0]  cfg_sel = '0;
    logic [19:0] cfg_data = '0;
    logic [3:0]  req_in = '0;
    logic [3:0]  sw_trig = '0;
    logic        bus_req, bus_gnt, mem_re, mem_we, mem_wide;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [3:0]  irq;
    logic        gnt_en = 1'b1;

    int ntest = 0, nfail = 0;
    bit finished = 0;

    logic [15:0] mem [1024];
    logic [19:0] log_addr [64];
    logic [15:0] log_data [64];
    int nwr = 0;
    int irq_cnt [4];
    int irq_run [4];
    int irq_max = 0;
    int run = 0, last_run = 0;

    always #5 clk = ~clk;

    assign bus_gnt   = bus_req && gnt_en;
    assign mem_rdata = mem[mem_addr[9:0]];

    steal_dma u_steal_dma (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .req_in(req_in),
        .sw_trig(sw_trig), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wide(mem_wide), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq(irq)
    );

    function automatic logic [15:0] pat(input int i);
        return 16'((i * 257) ^ 23100);
    endfunction

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:0]] <= mem_wide ? mem_wdata : {8'h00, mem_wdata[7:0]};
    end

    always @(negedge clk) begin
        if (mem_we && nwr < 64) begin
            log_addr[nwr] = mem_addr;
            log_data[nwr] = mem_wdata;
            nwr++;
        end
        for (int i = 0; i < 4; i++) begin
            if (irq[i]) begin
                irq_cnt[i]++;
                irq_run[i]++;
                if (irq_run[i] > irq_max) irq_max = irq_run[i];
            end else begin
                irq_run[i] = 0;
            end
        end
        if (bus_req) run++;
        else if (run != 0) begin
            last_run = run;
            run = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        ntest++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int sel, input logic [19:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_sel = 2'(sel); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int ch, input logic [19:0] s, input logic [19:0] d,
                         input logic [15:0] rl, input logic [4:0] ctl);
        wr(ch, 3, 20'h0);
        wr(ch, 0, s);
        wr(ch, 1, d);
        wr(ch, 2, {4'h0, rl});
        wr(ch, 3, {15'h0, ctl});
    endtask

    task automatic clear_log();
        @(posedge clk);
        nwr = 0;
        for (int i = 0; i < 4; i++) irq_cnt[i] = 0;
    endtask

    task automatic pulse(input int ch, input bit sw);
        @(negedge clk);
        if (sw) sw_trig[ch] = 1'b1; else req_in[ch] = 1'b1;
        @(negedge clk);
        sw_trig = '0; req_in = '0;
        repeat (7) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++; ntest++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", ntest, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = pat(i);
        for (int i = 0; i < 4; i++) begin irq_cnt[i] = 0; irq_run[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 R8 reset state
        chk("R11 reset bus_req", 32'(bus_req), 0);
        chk("R11 reset mem_we", 32'(mem_we), 0);
        chk("R8 reset irq", 32'(irq), 0);

        // Sweep: channel x width x direction, single mode, reload 2
        for (int ch = 0; ch < 4; ch++) begin
            for (int wd = 0; wd < 2; wd++) begin
                for (int dm = 0; dm < 3; dm++) begin
                    logic [19:0] s, d, sa, da;
                    logic [15:0] ed;
                    int st;
                    s  = 20'hA0100 + 20'(ch * 16 + wd * 64);
                    d  = 20'h50200 + 20'(ch * 16);
                    st = wd ? 2 : 1;
                    setup(ch, s, d, 16'd2,
                          {dm == 1, dm == 0, 1'b0, wd[0], 1'b1});
                    clear_log();
                    for (int p = 0; p < 4; p++) pulse(ch, 0);
                    repeat (10) @(negedge clk);
                    chk("R5 R6 transfers in single run", 32'(nwr), 3);
                    chk("R5 one irq at underflow", 32'(irq_cnt[ch]), 1);
                    for (int k = 0; k < 3; k++) begin
                        sa = s + ((dm == 0) ? 20'(k * st) : 20'h0);
                        da = d + ((dm == 1) ? 20'(k * st) : 20'h0);
                        ed = wd ? pat(int'(sa[9:0])) : {8'h00, pat(int'(sa[9:0]))[7:0]};
                        chk("R3 R4 write address", 32'(log_addr[k]), 32'(da));
                        chk("R2 write data", 32'(log_data[k]), 32'(ed));
                    end
                    chk("R11 bus held 3 cycles", 32'(last_run), 3);
                end
            end
        end

        // R1 priority: all four latched while grant withheld
        for (int ch = 0; ch < 4; ch++)
            setup(ch, 20'h00140 + 20'(ch), 20'h00300 + 20'(ch), 16'd0, 5'b00001);
        gnt_en = 1'b0;
        clear_log();
        @(negedge clk); req_in = 4'hF;
        @(negedge clk); req_in = '0;
        repeat (4) @(negedge clk);
        chk("R11 no data before grant", 32'(nwr), 0);
        gnt_en = 1'b1;
        repeat (30) @(negedge clk);
        chk("R1 count", 32'(nwr), 4);
        for (int k = 0; k < 4; k++)
            chk("R1 order", 32'(log_addr[k]), 32'(20'h00300 + 20'(k)));
        for (int ch = 0; ch < 4; ch++)
            setup(ch, 20'h00140 + 20'(ch), 20'h00300 + 20'(ch), 16'd0, 5'b00001);
        gnt_en = 1'b0;
        clear_log();
        @(negedge clk); req_in = 4'b1010;
        @(negedge clk); req_in = '0;
        repeat (3) @(negedge clk);
        gnt_en = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1 partial count", 32'(nwr), 2);
        chk("R1 partial first", 32'(log_addr[0]), 32'h00301);
        chk("R1 partial second", 32'(log_addr[1]), 32'h00303);

        // R7 repeat mode, word, source advancing, reload 1
        setup(1, 20'h00180, 20'h00220, 16'd1, 5'b01111);
        clear_log();
        for (int p = 0; p < 5; p++) pulse(1, 0);
        repeat (10) @(negedge clk);
        chk("R7 repeat keeps going", 32'(nwr), 5);
        chk("R7 irq every two", 32'(irq_cnt[1]), 2);
        chk("R7 pointer continues", 32'(log_data[4]), 32'(pat(16'h180 + 8)));
        wr(1, 3, 20'h0000E);
        clear_log();
        pulse(1, 0);
        repeat (10) @(negedge clk);
        chk("R6 R9 disabled ignores request", 32'(nwr), 0);

        // R9 request while disabled is dropped
        wr(2, 3, 20'h0);
        pulse(2, 0);
        setup(2, 20'h001A0, 20'h00230, 16'd0, 5'b00001);
        clear_log();
        repeat (12) @(negedge clk);
        chk("R9 dropped request", 32'(nwr), 0);
        pulse(2, 0);
        repeat (10) @(negedge clk);
        chk("R9 later request served", 32'(nwr), 1);

        // R10 re-enable restarts from presets
        setup(2, 20'h001C0, 20'h00240, 16'd3, 5'b01001);
        pulse(2, 0); pulse(2, 0);
        wr(2, 3, 20'h00008);
        wr(2, 3, 20'h00009);
        clear_log();
        for (int p = 0; p < 5; p++) pulse(2, 0);
        repeat (10) @(negedge clk);
        chk("R10 restart from source preset", 32'(log_data[0]), 32'({8'h00, pat(16'h1C0)[7:0]}));
        chk("R10 counter reloaded", 32'(nwr), 4);
        chk("R10 irq once", 32'(irq_cnt[2]), 1);

        // R12 latch does not queue
        setup(0, 20'h00150, 20'h00250, 16'd5, 5'b00001);
        gnt_en = 1'b0;
        clear_log();
        pulse(0, 0); pulse(0, 0);
        chk("R12 wait for grant", 32'(nwr), 0);
        gnt_en = 1'b1;
        repeat (20) @(negedge clk);
        chk("R12 single transfer", 32'(nwr), 1);

        // R13 software trigger
        setup(3, 20'h00170, 20'h00270, 16'd0, 5'b00001);
        clear_log();
        pulse(3, 1);
        repeat (10) @(negedge clk);
        chk("R13 sw trigger transfer", 32'(nwr), 1);
        chk("R13 sw trigger irq", 32'(irq_cnt[3]), 1);

        // R4 both-advance setting stored as both fixed
        setup(0, 20'h00160, 20'h00260, 16'd1, 5'b11001);
        clear_log();
        pulse(0, 0); pulse(0, 0);
        repeat (10) @(negedge clk);
        chk("R4 count", 32'(nwr), 2);
        chk("R4 dst fixed", 32'(log_addr[1]), 32'h00260);
        chk("R4 src fixed", 32'(log_data[1]), 32'({8'h00, pat(16'h160)[7:0]}));

        // R8 pulse width over the whole run
        chk("R8 irq one cycle", 32'(irq_max), 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end
endmodule